// File: doc/BRIEF.md
# I2C Write-Only Register Target

This block is an I2C target that only accepts writes. It holds nine byte-wide registers and shows their contents on parallel outputs. Every transfer begins with a START. The controller then sends a select byte: a 7-bit address in the upper bits and the direction bit in bit 0. The block acknowledges this byte only when the upper seven bits equal the `DEV_ADDR` parameter and the direction bit is 0.

The next byte is a register index. The data bytes that follow are stored at that index and at the indices after it, one per byte. Each stored byte is acknowledged. An index outside the map is refused with a NACK, and the rest of that transfer is ignored. A burst that runs past the last register is refused from that point on.

The map, by index:

| Index | Contents | Output |
|---|---|---|
| 0 | control | `ctrl_q` |
| 1 | LED | `led_q` |
| 2, 3, 4 | alarm value, most significant byte at index 2 | `alarm_q` |
| 5, 6, 7 | watch value, most significant byte at index 5 | `watch_q` |
| 8 | impedance | `imped_q` |

Both bus lines are passed through two flip-flops onto the system clock before they are used. A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. The block acknowledges by pulling SDA low through the open-drain enable `sda_oe`. The register outputs are plain levels, so this block has no streaming interface and no back-pressure.

Top module: `i2c_write_regs`

## Requirements
- R1: After reset, every register output is zero and `sda_oe` is 0 (SDA released).
- R2: A select byte equal to {`DEV_ADDR`, 1'b0} is acknowledged: SDA is held low for the whole high phase of the ninth SCL pulse.
- R3: A select byte whose address differs from `DEV_ADDR`, or whose bit 0 is 1, is not acknowledged. Every later byte is also refused and nothing is stored until the next START.
- R4: A register index below 9 is acknowledged. Each following data byte is stored at the current index and acknowledged, and the index then increases by one.
- R5: A register index of 9 or more is refused with a NACK. Every data byte after it is also refused and changes no register until STOP.
- R6: Once the index has passed 8, further data bytes are refused and discarded, and the bytes already written are kept.
- R7: `ctrl_q` shows index 0 and `led_q` shows index 1. `alarm_q` is {idx2, idx3, idx4}, `watch_q` is {idx5, idx6, idx7}, and `imped_q` shows index 8.
- R8: A repeated START returns the block to the select-byte phase, even in the middle of a data burst.
- R9: A STOP ends the transfer and releases SDA. Bytes clocked after a STOP without a new START are refused and not stored.
- R10: `sda_oe` changes only while the synchronized SCL is low, so it is stable throughout each SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain acknowledge) |
| ctrl_q | output | 8 | Control register (index 0) |
| led_q | output | 8 | LED register (index 1) |
| alarm_q | output | 24 | Alarm value, indices 2..4, MSB first |
| watch_q | output | 24 | Watch value, indices 5..7, MSB first |
| imped_q | output | 8 | Impedance register (index 8) |

## Verification
The bench sweeps every starting index with a burst one byte longer than what remains of the map. A design that lets the index wrap or run on would overwrite index 0 or acknowledge the extra byte. Select bytes with each single address bit flipped, or with the direction bit set, must get a NACK and must leave the registers unchanged; a loose address compare would acknowledge some of them and store data. Indices just past the map and far past it must refuse the following data, where an unclamped index would alias onto a real register. A repeated START inside a burst, and bytes clocked after a STOP, are also driven: a design that stayed in the data phase would acknowledge and store them.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W    = 8;
  localparam int NREG      = 9;
  localparam int PTR_W     = $clog2(NREG + 1);
  localparam int CTRL_IDX  = 0;
  localparam int LED_IDX   = 1;
  localparam int ALARM_IDX = 2;
  localparam int WATCH_IDX = 5;
  localparam int IMP_IDX   = 8;
  localparam int VAL_BYTES = 3;
  localparam int VAL_W     = VAL_BYTES * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SELECT,
    PH_INDEX,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] line_s;
  logic [LINES-1:0] line_p;

  assign raw = {sda_i, scl_i};

  // One synchronizer chain per bus line; idle level is high.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign line_s[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_p <= '1;
    else        line_p <= line_s;
  end

  assign scl_s     = line_s[0];
  assign sda_s     = line_s[1];
  assign scl_rise  = line_s[0] & ~line_p[0];
  assign scl_fall  = ~line_s[0] & line_p[0];
  assign start_det = line_s[0] & line_p[0] & line_p[1] & ~line_s[1];
  assign stop_det  = line_s[0] & line_p[0] & ~line_p[1] & line_s[1];
endmodule

// File: rtl/i2cw_bytefsm.sv
module i2cw_bytefsm
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h51
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);
  localparam logic [3:0]        LAST_BIT = 4'(BYTE_W);
  localparam logic [BYTE_W-1:0] NREG_B   = BYTE_W'(NREG);
  localparam logic [PTR_W-1:0]  NREG_P   = PTR_W'(NREG);

  phase_t            phase, phase_nx;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              in_ack;
  logic [PTR_W-1:0]  ptr, ptr_nx;
  logic              ack_c;
  logic              byte_done;
  logic              bus_event;

  assign bus_event = start_det | stop_det;
  assign byte_done = scl_fall && !in_ack && (bit_cnt == LAST_BIT) &&
                     (phase != PH_IDLE) && !bus_event;

  // Decision taken when the eighth bit has been clocked in.
  always_comb begin
    ack_c    = 1'b0;
    phase_nx = phase;
    ptr_nx   = ptr;
    case (phase)
      PH_SELECT: begin
        ack_c    = (shreg[BYTE_W-1:1] == DEV_ADDR) && !shreg[0];
        phase_nx = ack_c ? PH_INDEX : PH_SKIP;
      end
      PH_INDEX: begin
        ack_c    = shreg < NREG_B;
        phase_nx = ack_c ? PH_DATA : PH_SKIP;
        if (ack_c) ptr_nx = shreg[PTR_W-1:0];
      end
      PH_DATA: begin
        ack_c  = ptr < NREG_P;
        ptr_nx = ack_c ? ptr + 1'b1 : ptr;
      end
      default: begin
        ack_c    = 1'b0;
        phase_nx = phase;
      end
    endcase
  end

  assign wr_en   = byte_done && (phase == PH_DATA) && (ptr < NREG_P);
  assign wr_addr = ptr;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      in_ack  <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
    end else if (start_det) begin
      phase   <= PH_SELECT;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      in_ack  <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (scl_rise && !in_ack && (bit_cnt < LAST_BIT)) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (scl_fall) begin
        if (in_ack) begin
          in_ack  <= 1'b0;
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
        end else if (bit_cnt == LAST_BIT) begin
          in_ack <= 1'b1;
          sda_oe <= ack_c;
          phase  <= phase_nx;
          ptr    <= ptr_nx;
        end
      end
    end
  end
endmodule

// File: rtl/i2cw_regfile.sv
module i2cw_regfile
  import i2cw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [PTR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output logic [NREG*BYTE_W-1:0] bytes_q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && (wr_addr == PTR_W'(g)))   q <= wr_data;
    end
    assign bytes_q[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/i2c_write_regs.sv
module i2c_write_regs
  import i2cw_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h51,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe,
  output logic [BYTE_W-1:0]  ctrl_q,
  output logic [BYTE_W-1:0]  led_q,
  output logic [VAL_W-1:0]   alarm_q,
  output logic [VAL_W-1:0]   watch_q,
  output logic [BYTE_W-1:0]  imped_q
);
  logic                   scl_s, sda_s, scl_rise, scl_fall;
  logic                   start_det, stop_det;
  logic                   wr_en;
  logic [PTR_W-1:0]       wr_addr;
  logic [BYTE_W-1:0]      wr_data;
  logic [NREG*BYTE_W-1:0] reg_bytes;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_bytefsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  i2cw_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bytes_q(reg_bytes)
  );

  assign ctrl_q  = reg_bytes[CTRL_IDX*BYTE_W +: BYTE_W];
  assign led_q   = reg_bytes[LED_IDX*BYTE_W +: BYTE_W];
  assign imped_q = reg_bytes[IMP_IDX*BYTE_W +: BYTE_W];

  // Multi-byte values: lowest index lands in the most significant byte.
  for (genvar k = 0; k < VAL_BYTES; k++) begin : g_val
    assign alarm_q[(VAL_BYTES-1-k)*BYTE_W +: BYTE_W] =
      reg_bytes[(ALARM_IDX+k)*BYTE_W +: BYTE_W];
    assign watch_q[(VAL_BYTES-1-k)*BYTE_W +: BYTE_W] =
      reg_bytes[(WATCH_IDX+k)*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker
  import i2cw_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   scl_s,
  input logic                   start_det,
  input logic                   stop_det,
  input logic                   sda_oe,
  input logic                   wr_en,
  input logic [PTR_W-1:0]       wr_addr,
  input logic [NREG*BYTE_W-1:0] reg_bytes
);
  // R10: the pull-down only moves while SCL is low.
  p_oe_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8: a START always releases SDA.
  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  // R9: a STOP always releases SDA.
  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  // R4: every stored byte is acknowledged.
  p_write_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sda_oe);

  // R6: no write ever targets an index past the map.
  p_write_in_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr < PTR_W'(NREG)));

  // R5: registers hold unless a write strobe occurs.
  p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(reg_bytes));
endmodule

bind i2c_write_regs i2cw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr),
  .reg_bytes(reg_bytes)
);

// File: tb/i2c_write_regs_test.sv
`timescale 1ns/1ps
module i2c_write_regs_test;
  localparam logic [6:0] DEV = 7'h51;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [7:0]  ctrl_q, led_q, imped_q;
  logic [23:0] alarm_q, watch_q;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_r [9];
  int ptr_m;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  i2c_write_regs #(.DEV_ADDR(DEV)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .ctrl_q(ctrl_q), .led_q(led_q), .alarm_q(alarm_q),
    .watch_q(watch_q), .imped_q(imped_q)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  // Sends one byte; returns 1 on ACK. Also checks R10 (stable during high).
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq();
    a1 = ~sda_bus; wq();
    a2 = ~sda_bus;
    m_scl = 1'b0; wq();
    chk("R10 ack level stable over SCL high", {31'd0, a2}, {31'd0, a1});
    ack = a1;
  endtask

  task automatic cmp_all(input string req);
    chk({req, " R7 ctrl"},  {24'd0, ctrl_q},  {24'd0, exp_r[0]});
    chk({req, " R7 led"},   {24'd0, led_q},   {24'd0, exp_r[1]});
    chk({req, " R7 alarm"}, {8'd0, alarm_q},  {8'd0, exp_r[2], exp_r[3], exp_r[4]});
    chk({req, " R7 watch"}, {8'd0, watch_q},  {8'd0, exp_r[5], exp_r[6], exp_r[7]});
    chk({req, " R7 imped"}, {24'd0, imped_q}, {24'd0, exp_r[8]});
  endtask

  // Data byte inside a good transfer: update model, check ack.
  task automatic data_byte(input logic [7:0] d);
    logic a;
    send_byte(d, a);
    if (ptr_m < 9) begin
      chk("R4 data byte acked", {31'd0, a}, 32'd1);
      exp_r[ptr_m] = d;
      ptr_m++;
    end else begin
      chk("R6 byte past map refused", {31'd0, a}, 32'd0);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog all-R: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic a;
    for (int i = 0; i < 9; i++) exp_r[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 sda released", {31'd0, sda_oe}, 32'd0);
    cmp_all("R1");
    rst_n = 1'b1;
    wq();

    // R2/R4/R6/R7: burst from every index, one byte past the end
    for (int s = 0; s < 9; s++) begin
      bus_start();
      send_byte({DEV, 1'b0}, a);
      chk("R2 select acked", {31'd0, a}, 32'd1);
      send_byte(8'(s), a);
      chk("R4 index acked", {31'd0, a}, 32'd1);
      ptr_m = s;
      for (int k = 0; k < 10 - s; k++) data_byte(8'((s * 37 + k * 11 + 5) & 255));
      bus_stop();
      cmp_all("R6 burst");
    end

    // R3: wrong address bits or read direction
    for (int b = 0; b < 8; b++) begin
      logic [7:0] sel;
      sel = (b < 7) ? {DEV ^ 7'(1 << b), 1'b0} : {DEV, 1'b1};
      bus_start();
      send_byte(sel, a);
      chk("R3 select refused", {31'd0, a}, 32'd0);
      send_byte(8'd0, a);
      chk("R3 later byte refused", {31'd0, a}, 32'd0);
      send_byte(8'hA5, a);
      chk("R3 data refused", {31'd0, a}, 32'd0);
      bus_stop();
      cmp_all("R3");
    end

    // R5: out-of-map register index
    for (int j = 0; j < 6; j++) begin
      logic [7:0] idx;
      case (j)
        0: idx = 8'd9;  1: idx = 8'd10; 2: idx = 8'd15;
        3: idx = 8'd16; 4: idx = 8'h80; default: idx = 8'hFF;
      endcase
      bus_start();
      send_byte({DEV, 1'b0}, a);
      chk("R2 select acked", {31'd0, a}, 32'd1);
      send_byte(idx, a);
      chk("R5 bad index refused", {31'd0, a}, 32'd0);
      send_byte(8'h3C, a);
      chk("R5 data after bad index refused", {31'd0, a}, 32'd0);
      send_byte(8'hC3, a);
      chk("R5 second data refused", {31'd0, a}, 32'd0);
      bus_stop();
      cmp_all("R5");
    end

    // R8: repeated START inside a burst returns to select phase
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd3, a);
    ptr_m = 3;
    data_byte(8'h9E);
    bus_start();
    send_byte(8'h01, a);
    chk("R8 non-select byte after restart refused", {31'd0, a}, 32'd0);
    bus_start();
    send_byte({DEV, 1'b0}, a);
    chk("R8 select after restart acked", {31'd0, a}, 32'd1);
    send_byte(8'd6, a);
    chk("R8 index after restart acked", {31'd0, a}, 32'd1);
    ptr_m = 6;
    data_byte(8'h4D);
    bus_stop();
    cmp_all("R8");

    // R9: bytes after STOP without START are ignored
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd1, a);
    ptr_m = 1;
    data_byte(8'h6B);
    bus_stop();
    m_scl = 1'b0; wq();
    send_byte(8'h77, a);
    chk("R9 byte after stop refused", {31'd0, a}, 32'd0);
    send_byte(8'h11, a);
    chk("R9 second byte after stop refused", {31'd0, a}, 32'd0);
    m_scl = 1'b1; wq();
    bus_stop();
    chk("R9 sda released after stop", {31'd0, sda_oe}, 32'd0);
    cmp_all("R9");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule